// File: doc/BRIEF.md
# Trigger Emulator and Event Header Builder

This block replaces a timing-distribution receiver in a detector readout controller when no timing system is connected. Level-1 and level-2 trigger pulses arrive on direct inputs. A local emulator keeps a bunch-crossing counter and an orbit counter that follow the accelerator's orbit structure, and it also keeps an event counter. Every accepted level-1 trigger records its event, orbit and bunch-crossing numbers in a small first-in first-out store.

A later level-2 decision consumes the oldest record. An accept turns that record into a four-word header on a valid/ready stream. A reject discards the record. A busy output asks the trigger side to hold off while the store is nearly full or while a header is still leaving the block. All logic runs in one clock domain, nominally 40 MHz.

Top module: `trig_hdr_emu`

## Requirements
- R1: The bunch-crossing counter counts 0, 1, ... 3563 and then returns to 0, advancing once per clock. Each return to 0 increments a 24-bit orbit counter. Both values are stored with each level-1 record and appear in header words 3 (bits 11:0) and 2 (bits 23:0).
- R2: A 24-bit event counter increments on every `l1a_i` pulse. A record carries the value after the increment, and that value appears in header word 1, bits 23:0.
- R3: The store holds up to 4 records. A level-1 pulse that arrives while 4 records are held is dropped, and it sets `ovf_o`, which stays set until reset.
- R4: A level-2 accept that the block takes pops the oldest record and emits four words in this order: word 0 = 0xCAFE in bits 31:16, zero in bits 15:8 and status in bits 7:0; then the event number; then the orbit number; then the bunch-crossing number. All unused upper bits are zero.
- R5: `hdr_valid_o` rises in the cycle after the level-2 accept. Each word is held stable until a cycle with `hdr_ready_i` high, and the block advances by one word per handshake. Valid falls after the fourth handshake.
- R6: A level-2 reject that the block takes pops the oldest record and emits no word.
- R7: A level-2 pulse is taken only when the store is not empty and no header is in flight. Any other level-2 pulse pops nothing and sets `l2err_o`, which stays set until reset.
- R8: `busy_o` is high exactly when the store holds 3 or more records or `hdr_valid_o` is high.
- R9: A synchronous active-high reset empties the store, clears the counters and both flags, and drops valid and busy.
- R10: The status byte in word 0 is {6'b0, error flag, overflow flag}, as the flags stood before the cycle of the level-2 accept.
- R11: When `l2a_i` and `l2r_i` are high together, the pulse is treated as an accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| l1a_i | input | 1 | Level-1 accept pulse |
| l2a_i | input | 1 | Level-2 accept pulse |
| l2r_i | input | 1 | Level-2 reject pulse |
| hdr_ready_i | input | 1 | Downstream ready for a header word |
| hdr_data_o | output | 32 | Header word |
| hdr_valid_o | output | 1 | Header word valid |
| busy_o | output | 1 | Hold-off toward the trigger source |
| ovf_o | output | 1 | Sticky level-1 overflow flag |
| l2err_o | output | 1 | Sticky level-2 error flag |

## Verification
A wrong store pointer or count shows up at the ports in several ways. The next header can carry the wrong event, orbit or bunch-crossing number. Busy can switch at the wrong occupancy. A level-2 pulse can wrongly raise the error flag. Each of these appears within a few cycles of the faulty push or pop. A drift in the bunch-crossing or orbit emulator appears in the very next header. The bench compares every cycle against a model that runs in step with the design, so a fault is reported on the clock where it first reaches an output.

// File: rtl/tre_pkg.sv
package tre_pkg;
  localparam int EV_W      = 24;
  localparam int ORB_W     = 24;
  localparam int BC_W      = 12;
  localparam int WORD_W    = 32;
  localparam int STAT_W    = 8;
  localparam int MARK_W    = 16;
  localparam int HDR_WORDS = 4;
  localparam logic [MARK_W-1:0] HDR_MARK = 16'hCAFE;

  typedef struct packed {
    logic [EV_W-1:0]  ev;
    logic [ORB_W-1:0] orb;
    logic [BC_W-1:0]  bc;
  } trig_rec_t;
endpackage

// File: rtl/tre_counters.sv
module tre_counters
  import tre_pkg::*;
#(
  parameter int BC_MAX = 3563
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             l1_i,
  output logic [BC_W-1:0]  bc_o,
  output logic [ORB_W-1:0] orb_o,
  output logic [EV_W-1:0]  ev_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      bc_o  <= '0;
      orb_o <= '0;
      ev_o  <= '0;
    end else begin
      if (bc_o == BC_W'(BC_MAX)) begin
        bc_o  <= '0;
        orb_o <= orb_o + 1'b1;
      end else begin
        bc_o <= bc_o + 1'b1;
      end
      if (l1_i) ev_o <= ev_o + 1'b1;
    end
  end
endmodule

// File: rtl/tre_store.sv
module tre_store
  import tre_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          push_i,
  input  logic                          pop_i,
  input  trig_rec_t                     rec_i,
  output trig_rec_t                     rec_o,
  output logic [$clog2(DEPTH+1)-1:0]    cnt_o,
  output logic                          full_o,
  output logic                          empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  trig_rec_t       mem [DEPTH];
  logic [AW-1:0]   wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_ptr] <= rec_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_o  <= '0;
    end else begin
      if (push_i) wr_ptr <= nxt(wr_ptr);
      if (pop_i)  rd_ptr <= nxt(rd_ptr);
      case ({push_i, pop_i})
        2'b10:   cnt_o <= cnt_o + 1'b1;
        2'b01:   cnt_o <= cnt_o - 1'b1;
        default: cnt_o <= cnt_o;
      endcase
    end
  end

  assign rec_o   = mem[rd_ptr];
  assign full_o  = (cnt_o == CW'(DEPTH));
  assign empty_o = (cnt_o == '0);
endmodule

// File: rtl/tre_hdr_seq.sv
module tre_hdr_seq
  import tre_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  trig_rec_t         rec_i,
  input  logic [STAT_W-1:0] stat_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] data_o
);
  localparam int IW = $clog2(HDR_WORDS);

  trig_rec_t         rec_q;
  logic [STAT_W-1:0] stat_q;
  logic [IW-1:0]     idx_q;

  function automatic logic [WORD_W-1:0] pick(input trig_rec_t r,
                                             input logic [STAT_W-1:0] s,
                                             input logic [IW-1:0] i);
    case (i)
      2'd0:    return {HDR_MARK, {(WORD_W-MARK_W-STAT_W){1'b0}}, s};
      2'd1:    return {{(WORD_W-EV_W){1'b0}}, r.ev};
      2'd2:    return {{(WORD_W-ORB_W){1'b0}}, r.orb};
      default: return {{(WORD_W-BC_W){1'b0}}, r.bc};
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      idx_q   <= '0;
      data_o  <= '0;
      rec_q   <= '0;
      stat_q  <= '0;
    end else if (load_i) begin
      rec_q   <= rec_i;
      stat_q  <= stat_i;
      idx_q   <= '0;
      valid_o <= 1'b1;
      data_o  <= pick(rec_i, stat_i, '0);
    end else if (valid_o && ready_i) begin
      if (idx_q == IW'(HDR_WORDS - 1)) begin
        valid_o <= 1'b0;
      end else begin
        idx_q  <= idx_q + 1'b1;
        data_o <= pick(rec_q, stat_q, idx_q + 1'b1);
      end
    end
  end
endmodule

// File: rtl/trig_hdr_emu.sv
module trig_hdr_emu
  import tre_pkg::*;
#(
  parameter int BC_MAX   = 3563,
  parameter int DEPTH    = 4,
  parameter int BUSY_LVL = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l1a_i,
  input  logic              l2a_i,
  input  logic              l2r_i,
  input  logic              hdr_ready_i,
  output logic [WORD_W-1:0] hdr_data_o,
  output logic              hdr_valid_o,
  output logic              busy_o,
  output logic              ovf_o,
  output logic              l2err_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [BC_W-1:0]  bc_w;
  logic [ORB_W-1:0] orb_w;
  logic [EV_W-1:0]  ev_w;
  logic [CW-1:0]    cnt_w;
  logic             full_w, empty_w;
  trig_rec_t        new_rec, head_rec;
  logic             l2_any, l2_take, push_w, load_w;

  assign l2_any  = l2a_i | l2r_i;
  assign l2_take = l2_any && !empty_w && !hdr_valid_o;
  assign push_w  = l1a_i && !full_w;
  assign load_w  = l2_take && l2a_i;

  assign new_rec.ev  = ev_w + 1'b1;
  assign new_rec.orb = orb_w;
  assign new_rec.bc  = bc_w;

  tre_counters #(.BC_MAX(BC_MAX)) u_cnt (
    .clk(clk), .rst(rst), .l1_i(l1a_i),
    .bc_o(bc_w), .orb_o(orb_w), .ev_o(ev_w)
  );

  tre_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .push_i(push_w), .pop_i(l2_take),
    .rec_i(new_rec), .rec_o(head_rec), .cnt_o(cnt_w),
    .full_o(full_w), .empty_o(empty_w)
  );

  tre_hdr_seq u_seq (
    .clk(clk), .rst(rst), .load_i(load_w), .rec_i(head_rec),
    .stat_i({{(STAT_W-2){1'b0}}, l2err_o, ovf_o}),
    .ready_i(hdr_ready_i), .valid_o(hdr_valid_o), .data_o(hdr_data_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ovf_o   <= 1'b0;
      l2err_o <= 1'b0;
    end else begin
      if (l1a_i && full_w)     ovf_o   <= 1'b1;
      if (l2_any && !l2_take)  l2err_o <= 1'b1;
    end
  end

  assign busy_o = (cnt_w >= CW'(BUSY_LVL)) || hdr_valid_o;
endmodule

// File: rtl/tre_chk.sv
module tre_chk #(
  parameter int BC_MAX = 3563
) (
  input logic        clk,
  input logic        rst,
  input logic        l2a,
  input logic        l2r,
  input logic        ready,
  input logic        valid,
  input logic [31:0] data,
  input logic        busy,
  input logic        ovf,
  input logic        err,
  input logic [11:0] bc
);
  AST_BC_RANGE: assert property (@(posedge clk) disable iff (rst)
    bc <= 12'(BC_MAX)); // R1
  AST_BC_WRAP: assert property (@(posedge clk) disable iff (rst)
    (bc == 12'(BC_MAX)) |=> (bc == 12'd0)); // R1
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf); // R3
  AST_HDR_MARKER: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> (data[31:16] == 16'hCAFE)); // R4
  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> (valid && $stable(data))); // R5
  AST_REJECT_SILENT: assert property (@(posedge clk) disable iff (rst)
    (l2r && !l2a && !valid) |=> !valid); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err |=> err); // R7
  AST_BUSY_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
    valid |-> busy); // R8
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (!valid && !busy && !ovf && !err)); // R9
endmodule

bind trig_hdr_emu tre_chk u_chk (
  .clk(clk), .rst(rst), .l2a(l2a_i), .l2r(l2r_i), .ready(hdr_ready_i),
  .valid(hdr_valid_o), .data(hdr_data_o), .busy(busy_o),
  .ovf(ovf_o), .err(l2err_o), .bc(bc_w)
);

// File: tb/trig_hdr_emu_test.sv
`timescale 1ns/1ps
module trig_hdr_emu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        l1a = 1'b0, l2a = 1'b0, l2r = 1'b0, rdy = 1'b0;
  logic [31:0] data;
  logic        valid, busy, ovf, err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model state
  logic [11:0] m_bc;
  logic [23:0] m_orb, m_ev;
  logic [23:0] q_ev [4];
  logic [23:0] q_orb [4];
  logic [11:0] q_bc [4];
  int          m_cnt, m_idx;
  bit          m_ovf, m_err, m_v;
  logic [23:0] e_ev, e_orb;
  logic [11:0] e_bc;
  logic [7:0]  e_stat;

  always #2.5 clk = ~clk;

  trig_hdr_emu uut (
    .clk(clk), .rst(rst), .l1a_i(l1a), .l2a_i(l2a), .l2r_i(l2r),
    .hdr_ready_i(rdy), .hdr_data_o(data), .hdr_valid_o(valid),
    .busy_o(busy), .ovf_o(ovf), .l2err_o(err)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_word(input int i);
    case (i)
      0:       return {16'hCAFE, 8'h00, e_stat};
      1:       return {8'h00, e_ev};
      2:       return {8'h00, e_orb};
      default: return {20'h0, e_bc};
    endcase
  endfunction

  function automatic string word_tag(input int i);
    case (i)
      0:       return "R10 word0";
      1:       return "R2 word1";
      2:       return "R1 word2";
      default: return "R1 word3";
    endcase
  endfunction

  task automatic model_reset();
    m_bc = '0; m_orb = '0; m_ev = '0;
    m_cnt = 0; m_idx = 0; m_ovf = 0; m_err = 0; m_v = 0;
  endtask

  task automatic compare_all();
    chk({31'b0, valid}, {31'b0, m_v}, "R5 valid");
    chk({31'b0, busy}, {31'b0, (m_cnt >= 3) || m_v}, "R8 busy");
    chk({31'b0, ovf}, {31'b0, m_ovf}, "R3 overflow");
    chk({31'b0, err}, {31'b0, m_err}, "R7 error");
    if (m_v) chk(data, exp_word(m_idx), word_tag(m_idx));
  endtask

  // one clock: drive at negedge, advance model, sample at next negedge
  task automatic cyc(input bit a1, input bit a2a, input bit a2r, input bit r);
    bit full, l2, ok;
    logic [7:0] st;
    l1a = a1; l2a = a2a; l2r = a2r; rdy = r;
    full = (m_cnt == 4);
    l2   = a2a | a2r;
    ok   = l2 && (m_cnt != 0) && !m_v;
    st   = {6'b0, m_err, m_ovf};
    if (ok && a2a) begin
      e_ev = q_ev[0]; e_orb = q_orb[0]; e_bc = q_bc[0]; e_stat = st;
      m_v = 1; m_idx = 0;
    end else if (m_v && r) begin
      if (m_idx == 3) m_v = 0; else m_idx++;
    end
    if (ok) begin
      for (int k = 0; k < 3; k++) begin
        q_ev[k] = q_ev[k+1]; q_orb[k] = q_orb[k+1]; q_bc[k] = q_bc[k+1];
      end
      m_cnt--;
    end
    if (a1 && !full) begin
      q_ev[m_cnt] = m_ev + 24'd1; q_orb[m_cnt] = m_orb; q_bc[m_cnt] = m_bc;
      m_cnt++;
    end
    if (a1 && full) m_ovf = 1;
    if (l2 && !ok)  m_err = 1;
    if (a1) m_ev = m_ev + 24'd1;
    if (m_bc == 12'd3563) begin m_bc = '0; m_orb = m_orb + 24'd1; end
    else m_bc = m_bc + 12'd1;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset();
    rst = 1'b1; l1a = 0; l2a = 0; l2r = 0; rdy = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    // R9: everything cleared after reset
    chk({28'b0, valid, busy, ovf, err}, 32'h0, "R9 reset state");
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();

    // R2 R4 R1: one trigger, accepted later, free-flowing ready
    repeat (10) cyc(0, 0, 0, 1);
    cyc(1, 0, 0, 1);
    repeat (5) cyc(0, 0, 0, 1);
    cyc(0, 1, 0, 1);
    repeat (6) cyc(0, 0, 0, 1);

    // R5: stalled downstream
    cyc(1, 0, 0, 0);
    cyc(0, 1, 0, 0);
    repeat (5) cyc(0, 0, 0, 0);
    repeat (3) begin cyc(0, 0, 0, 1); cyc(0, 0, 0, 0); end
    repeat (3) cyc(0, 0, 0, 1);

    // R6: reject pops and emits nothing
    cyc(1, 0, 0, 1);
    cyc(0, 0, 1, 1);
    cyc(0, 0, 0, 1);
    chk({31'b0, valid}, 32'h0, "R6 reject silent");

    // R3 R8: fill beyond depth
    repeat (6) cyc(1, 0, 0, 1);
    // R7: level-2 while a header is in flight
    cyc(0, 1, 0, 0);
    cyc(0, 1, 0, 0);
    repeat (8) cyc(0, 0, 0, 1);
    // R11: both level-2 inputs at once
    cyc(0, 1, 1, 1);
    chk({31'b0, valid}, 32'h1, "R11 both means accept");
    repeat (6) cyc(0, 0, 0, 1);
    // drain, then level-2 on empty store (R7)
    repeat (3) begin cyc(0, 0, 1, 1); cyc(0, 0, 0, 1); end
    cyc(0, 0, 1, 1);
    // simultaneous push and pop
    cyc(1, 0, 0, 1);
    cyc(1, 1, 0, 1);
    repeat (6) cyc(0, 0, 0, 1);

    // R9: reset mid-traffic, then check clean status in the next header
    cyc(1, 0, 0, 1);
    do_reset();
    cyc(1, 0, 0, 1);
    cyc(0, 1, 0, 1);
    repeat (5) cyc(0, 0, 0, 1);

    // random traffic across several orbit wraps (R1)
    for (int n = 0; n < 20000; n++) begin
      int   p;
      bit   a1, a2a, a2r, r;
      a1  = ($urandom % 8) == 0;
      p   = $urandom % 12;
      a2a = (p == 0);
      a2r = (p == 1);
      r   = ($urandom % 4) != 0;
      cyc(a1, a2a, a2r, r);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule